// File: doc/BRIEF.md
# MII Management Register Responder

This block plays the part of a PHY's management slave for a host that drives the management lines by software. Each host write to the control word supplies three bits at once: the management clock, the outgoing data bit and a read-direction flag. The block reacts only when a write raises the clock bit from 0 to 1. On each such edge it shifts one bit into a 32-bit word, decodes a read request after 16 edges and a write frame after 32 edges, and returns read data one bit per edge on `mdi_o`.

The responder answers a single PHY address and holds 32 registers of 16 bits. Each register has a reset value and a mask that selects which of its bits a write may change. A run of ones long enough to fill the shift word restarts the bit count, so a preamble always brings host and block back into step. All pins are plain control and status levels, with no valid/ready handshake. The host cannot stall the block and the block never stalls the host, because every control write is absorbed in the cycle it arrives.

Top module: `mii_mgmt_responder`

## Requirements
- R1: Only a control write that takes the clock bit from 0 to 1 advances the block. A write with the clock bit held at 1, or one that drops it to 0, leaves the bit position and the decoded results unchanged.
- R2: On a rising edge the bit shifted in is 1 only if data-out is 1 and either the count after this edge is below 16 or read-direction is 0. So during the data phase of a read with read-direction at 1, data-out has no effect on the returned bits.
- R3: When the count after an edge is 16 or more and read-direction is 1, `mdi_o` takes bit 15 of the shifted word. With read-direction at 0, `mdi_o` does not change.
- R4: When the shift word becomes all ones, the count returns to zero. After 32 ones, a frame decodes correctly whatever bits came before.
- R5: At count 16 the block decodes a read header: opcode in bits 15:12 equal to 6 (start plus read, sent as 0110), PHY in bits 11:7, register in bits 6:2. It then loads the register value, and the next 15 edges with read-direction at 1 return value bits 14 down to 0, most significant first.
- R6: At count 32 the block decodes a write frame: opcode in bits 31:28 equal to 5 (sent as 0101), PHY in 27:23, register in 22:18, data in 15:0. It then writes the register.
- R7: Only PHY address 1 responds. A read of another address returns all zeros, and a write to another address changes nothing.
- R8: A write stores new = (old AND NOT mask) OR (data AND mask). The masks are 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25, 0xC01F for register 4, 0x0FFF for register 16, and 0 for all other registers.
- R9: After reset, registers 0 to 5 hold 0x3100, 0xF02C, 0x7810, 0x0000, 0x0501 and 0x4181. Register 16 holds 0x0003, register 18 holds 0x0001, and every other register holds 0. `mdi_o` is 0 after reset.
- R10: A control write that does not produce a rising clock edge leaves `mdi_o` at its current value while the other control bits take their new values.
- R11: Frames whose opcode is neither 6 at count 16 nor 5 at count 32 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Host writes the control word this cycle |
| ctl_mdc | input | 1 | Management clock bit of the written word |
| ctl_mdo | input | 1 | Data-out bit of the written word |
| ctl_rd_dir | input | 1 | Read-direction bit of the written word |
| mdi_o | output | 1 | Data-in bit returned to the host |

## Verification
The bench builds the block with its default parameters: PHY address 1, a 16-bit header point, a 32-bit frame point and a 6-bit counter. With these values a preamble that follows a completed read pushes the counter through 33 to 63, where it saturates, before the all-ones word resets it. This exercises the saturating count and the resynchronisation together. The 32-entry bank is small enough for the bench to shadow every register's reset value and write mask, so reads can be checked against each mask class and against the unanswered address.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam logic [3:0] OP_READ  = 4'd6;
  localparam logic [3:0] OP_WRITE = 4'd5;

  function automatic logic [DATA_W-1:0] reg_default(int idx);
    case (idx)
      0:       return 16'h3100;
      1:       return 16'hF02C;
      2:       return 16'h7810;
      4:       return 16'h0501;
      5:       return 16'h4181;
      16:      return 16'h0003;
      18:      return 16'h0001;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_mask(int idx);
    case (idx)
      1, 2, 3, 5, 6:                    return 16'hFFFF;
      18, 19, 20, 21, 22, 23, 24, 25:   return 16'hFFFF;
      4:                                return 16'hC01F;
      16:                               return 16'h0FFF;
      default:                          return '0;
    endcase
  endfunction

endpackage

// File: rtl/mgmt_clk_sense.sv
module mgmt_clk_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic mdc_i,
  output logic step_o
);

  logic mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mdc_q <= 1'b0;
    else if (we_i) mdc_q <= mdc_i;
  end

  assign step_o = we_i & mdc_i & ~mdc_q;

  // R1: a step needs the clock bit low beforehand
  p_step_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> mdc_q);

endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import mii_mgmt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int NREG = NUM_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);

  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] wr_mask;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] MSK = DW'(reg_mask(g));
    localparam logic [DW-1:0] DEF = DW'(reg_default(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= DEF;
      else if (wr_en_i && wr_addr_i == AW'(g))
        mem[g] <= (mem[g] & ~MSK) | (wr_data_i & MSK);
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign wr_mask   = DW'(reg_mask(int'(wr_addr_i)));

  // R8: protected bits survive any write
  p_mask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((mem[$past(wr_addr_i)] & ~$past(wr_mask)) ==
                 ($past(mem[wr_addr_i]) & ~$past(wr_mask))));

  // R8: register 0 is read-only
  p_reg0_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> $stable(mem[0]));

endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mii_mgmt_pkg::*;
#(
  parameter int          FRAME_W = 32,
  parameter int          HDR_W   = 16,
  parameter int          CNT_W   = 6,
  parameter int          DW      = DATA_W,
  parameter int          AW      = ADDR_W,
  parameter int          PHY_W   = 5,
  parameter logic [4:0]  PHY_ID  = 5'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          din_i,
  input  logic          dir_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          mdi_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_FRM  = CNT_W'(FRAME_W);
  localparam int               H_PHY_LO = HDR_W - 4 - PHY_W;
  localparam int               H_REG_LO = H_PHY_LO - AW;
  localparam int               F_PHY_LO = FRAME_W - 4 - PHY_W;
  localparam int               F_REG_LO = F_PHY_LO - AW;

  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-1:0] word_q, word_n;
  logic               bit_in, all_ones;
  logic [3:0]         hdr_op, frm_op;
  logic [PHY_W-1:0]   hdr_phy, frm_phy;
  logic [DW-1:0]      rd_val;

  assign cnt_n    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign bit_in   = din_i && ((cnt_n < CNT_HDR) || !dir_i);
  assign word_n   = {word_q[FRAME_W-2:0], bit_in};
  assign all_ones = &word_n;

  assign hdr_op    = word_n[HDR_W-1 -: 4];
  assign hdr_phy   = word_n[H_PHY_LO +: PHY_W];
  assign rd_addr_o = word_n[H_REG_LO +: AW];
  assign rd_val    = (hdr_phy == PHY_ID) ? rd_data_i : '0;

  assign frm_op    = word_n[FRAME_W-1 -: 4];
  assign frm_phy   = word_n[F_PHY_LO +: PHY_W];
  assign wr_addr_o = word_n[F_REG_LO +: AW];
  assign wr_data_o = word_n[DW-1:0];
  assign wr_en_o   = step_i && !all_ones && (cnt_n == CNT_FRM) &&
                     (frm_op == OP_WRITE) && (frm_phy == PHY_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      mdi_o  <= 1'b0;
    end else if (step_i) begin
      cnt_q  <= cnt_n;
      word_q <= word_n;
      if ((cnt_n >= CNT_HDR) && dir_i)
        mdi_o <= word_n[HDR_W-1];
      if (all_ones)
        cnt_q <= '0;
      else if ((cnt_n == CNT_HDR) && (hdr_op == OP_READ))
        word_q <= FRAME_W'(rd_val);
    end
  end

  // R1: no edge, no progress
  p_no_step_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(cnt_q) && $stable(word_q)));

  // R10: data-in kept across writes without an edge
  p_mdi_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(mdi_o));

  // R3: data-in only moves while reading
  p_dir_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_i |=> $stable(mdi_o));

  // R4: all-ones word restarts the count
  p_resync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && all_ones) |=> (cnt_q == '0));

  // R5: a read load leaves the upper half clear
  p_rd_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !all_ones && cnt_n == CNT_HDR && hdr_op == OP_READ)
      |=> (word_q[FRAME_W-1:DW] == '0));

endmodule

// File: rtl/mii_mgmt_responder.sv
module mii_mgmt_responder
  import mii_mgmt_pkg::*;
#(
  parameter int         FRAME_W = 32,
  parameter int         HDR_W   = 16,
  parameter int         CNT_W   = 6,
  parameter logic [4:0] PHY_ID  = 5'd1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_mdc,
  input  logic ctl_mdo,
  input  logic ctl_rd_dir,
  output logic mdi_o
);

  logic              step;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  mgmt_clk_sense u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (ctl_we),
    .mdc_i  (ctl_mdc),
    .step_o (step)
  );

  mgmt_frame_engine #(
    .FRAME_W (FRAME_W),
    .HDR_W   (HDR_W),
    .CNT_W   (CNT_W),
    .DW      (DATA_W),
    .AW      (ADDR_W),
    .PHY_W   (5),
    .PHY_ID  (PHY_ID)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .din_i     (ctl_mdo),
    .dir_i     (ctl_rd_dir),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .mdi_o     (mdi_o)
  );

  mgmt_reg_bank #(
    .DW   (DATA_W),
    .AW   (ADDR_W),
    .NREG (NUM_REGS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

endmodule

// File: tb/mii_mgmt_responder_tb.sv
module mii_mgmt_responder_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_mdc = 1'b0, ctl_mdo = 1'b0, ctl_rd_dir = 1'b0;
  logic mdi_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] shadow [32];
  logic [15:0] exp_q[$];
  logic [15:0] obs_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mii_mgmt_responder u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mdc(ctl_mdc),
    .ctl_mdo(ctl_mdo), .ctl_rd_dir(ctl_rd_dir), .mdi_o(mdi_o)
  );

  function automatic logic [15:0] def_of(int i);
    case (i)
      0: return 16'h3100; 1: return 16'hF02C; 2: return 16'h7810;
      4: return 16'h0501; 5: return 16'h4181; 16: return 16'h0003;
      18: return 16'h0001; default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] msk_of(int i);
    if (i == 4) return 16'hC01F;
    if (i == 16) return 16'h0FFF;
    if ((i >= 1 && i <= 6) || (i >= 18 && i <= 25)) return 16'hFFFF;
    return 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic mdc, input logic mdo, input logic dir);
    @(negedge clk);
    ctl_we = 1'b1; ctl_mdc = mdc; ctl_mdo = mdo; ctl_rd_dir = dir;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic clk_bit(input logic b, input logic dir);
    put(1'b0, b, dir);
    put(1'b1, b, dir);
  endtask

  task automatic preamble();
    for (int i = 0; i < 32; i++) clk_bit(1'b1, 1'b0);
  endtask

  task automatic wr_frame(input logic [3:0] op, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] data);
    logic [31:0] f;
    f = {op, phy, rg, 2'b10, data};
    preamble();
    for (int i = 31; i >= 0; i--) clk_bit(f[i], 1'b0);
    if (op == 4'd5 && phy == 5'd1)
      shadow[rg] = (shadow[rg] & ~msk_of(int'(rg))) | (data & msk_of(int'(rg)));
  endtask

  // driver: pushes the expected word, then the observed one for the monitor
  task automatic rd_frame(input logic [4:0] phy, input logic [4:0] rg,
                          input logic mdo_dp, input bit probe, input string tag);
    logic [15:0] h, got, ex;
    logic        held;
    h = {4'b0110, phy, rg, 2'b00};
    ex = (phy == 5'd1) ? shadow[rg] : 16'h0000;
    exp_q.push_back({1'b0, ex[14:0]});
    tag_q.push_back(tag);
    preamble();
    for (int i = 15; i >= 0; i--) clk_bit(h[i], 1'b0);
    got = '0;
    for (int k = 1; k <= 16; k++) begin
      clk_bit(mdo_dp, 1'b1);
      if (k <= 15) got[15-k] = mdi_o;
      if (probe && k == 1) begin
        held = mdi_o;
        put(1'b1, ~mdo_dp, 1'b1);          // clock stays high: no edge
        chk(mdi_o == held, "R10 no-edge write keeps mdi", {15'd0, mdi_o}, {15'd0, held});
        put(1'b0, 1'b1, 1'b0);             // falling clock write
        chk(mdi_o == held, "R1 falling write ignored", {15'd0, mdi_o}, {15'd0, held});
      end
    end
    obs_q.push_back(got);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [15:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(o == e, t, o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = def_of(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdi_o == 1'b0, "R9 mdi after reset", {15'd0, mdi_o}, 16'h0000);

    // R9 reset values
    rd_frame(5'd1, 5'd0,  1'b0, 1'b0, "R9 reg0 default");
    rd_frame(5'd1, 5'd1,  1'b0, 1'b1, "R9 R5 reg1 default with no-edge probes");
    rd_frame(5'd1, 5'd2,  1'b0, 1'b0, "R9 reg2 default");
    rd_frame(5'd1, 5'd4,  1'b0, 1'b0, "R9 reg4 default");
    rd_frame(5'd1, 5'd5,  1'b0, 1'b0, "R9 reg5 default");
    rd_frame(5'd1, 5'd16, 1'b0, 1'b0, "R9 reg16 default");
    rd_frame(5'd1, 5'd18, 1'b0, 1'b0, "R9 reg18 default");
    rd_frame(5'd1, 5'd7,  1'b0, 1'b0, "R9 reg7 default");

    // R2 data-out ignored in data phase
    rd_frame(5'd1, 5'd2, 1'b1, 1'b0, "R2 mdo high during read data");

    // R7 other address reads zero
    rd_frame(5'd3, 5'd1, 1'b0, 1'b0, "R7 read other phy");

    // R6 / R8 writes
    wr_frame(4'd5, 5'd1, 5'd1, 16'hABCD);
    rd_frame(5'd1, 5'd1, 1'b0, 1'b0, "R6 reg1 full write");
    wr_frame(4'd5, 5'd1, 5'd4, 16'hFFFF);
    rd_frame(5'd1, 5'd4, 1'b0, 1'b0, "R8 reg4 masked write");
    wr_frame(4'd5, 5'd1, 5'd16, 16'hFFFF);
    rd_frame(5'd1, 5'd16, 1'b0, 1'b0, "R8 reg16 masked write");
    wr_frame(4'd5, 5'd1, 5'd0, 16'h0F0F);
    rd_frame(5'd1, 5'd0, 1'b0, 1'b0, "R8 reg0 read-only");
    wr_frame(4'd5, 5'd1, 5'd18, 16'h1234);
    rd_frame(5'd1, 5'd18, 1'b0, 1'b0, "R6 reg18 write");

    // R7 write to another address ignored
    wr_frame(4'd5, 5'd2, 5'd1, 16'h0000);
    rd_frame(5'd1, 5'd1, 1'b0, 1'b0, "R7 write other phy ignored");

    // R11 other opcodes
    wr_frame(4'd7, 5'd1, 5'd3, 16'h2222);
    wr_frame(4'd4, 5'd1, 5'd3, 16'h3333);
    rd_frame(5'd1, 5'd3, 1'b0, 1'b0, "R11 other opcodes no write");

    // R4 resync after garbage bits
    for (int i = 0; i < 7; i++) clk_bit(i[0], 1'b0);
    rd_frame(5'd1, 5'd5, 1'b0, 1'b0, "R4 resync after garbage");

    // R3 dir low: mdi holds through write frame bits
    begin
      logic held;
      held = mdi_o;
      wr_frame(4'd5, 5'd1, 5'd6, 16'h00FF);
      chk(mdi_o == held, "R3 mdi holds with dir low", {15'd0, mdi_o}, {15'd0, held});
    end
    rd_frame(5'd1, 5'd6, 1'b0, 1'b0, "R6 reg6 write");

    while (obs_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule